// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes of a classic 8-bit microcontroller's external memory bus. The first is the address-latch strobe, which tells an external latch when to capture the low address byte. The second is the program-read strobe, which gates external code memory onto the bus. The block runs on the oscillator clock. It divides time into machine cycles of twelve clocks, using a free-running phase counter.

At the clock edge that starts each machine cycle, the block samples its context inputs:
- where code is being fetched from;
- the external-execution strap;
- whether the cycle moves data to or from external data memory;
- whether the cycle reads a constant from code memory.

From these it decides which strobe pulses that cycle carries. A one-bit latch-disable setting sits in a small memory-mapped register. When it is set, the latch strobe is silenced during purely internal activity and the latch pin is handed to a weak pull-up. Any external access overrides the disable, and so does strapping the part for external execution.

Top module: `bus_strobe_gen`

## Requirements
- R1: While `rst_ni` is low, and for the first clock edge after it rises, `ale_o`, `rd_o` and `pull_o` are all low and `reg_rdata_o` reads 0. The disable bit resets to 0.
- R2: A machine cycle is 12 clocks, numbered phase 0 to 11. In an ordinary cycle `ale_o` is high in phases 0, 1, 6 and 7. That gives two pulses per cycle, each two clocks wide, at one sixth of the clock rate.
- R3: In a cycle marked as an external code fetch, `rd_o` is high in phases 3–5 and 9–11. Each read pulse therefore starts one clock after the latch strobe falls. `rd_o` stays low in every cycle that fetches internally.
- R4: In a cycle marked as a data-memory cycle (`movx_i` sampled high), the phase-6/7 latch pulse is dropped and both read pulses are dropped.
- R5: The config register answers at byte address 8Eh only. Bit 0 is the latch-disable bit. Bits 7:1 read 0 and ignore writes. A write to any other address changes nothing, and reads of other addresses return 0.
- R6: When the disable bit is 1, the strap selects internal execution, and the cycle is an internal fetch with neither `movx_i` nor `movc_i`, then `ale_o` stays low and `pull_o` is high for the whole machine cycle.
- R7: With the disable bit set, a cycle that has `movx_i`, `movc_i` or `ext_fetch_i` high still produces its latch pulses, and `pull_o` stays low.
- R8: With `ext_strap_i` high, the disable bit has no effect. The cycle is treated as an external code fetch, so read pulses appear and the latch pulses are present.
- R9: The cycle context is sampled only on the clock edge that ends phase 11. The first machine cycle after reset is an internal fetch with the latch strobe enabled. Inputs that change mid-cycle take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_fetch_i | input | 1 | Code for this cycle comes from external memory |
| ext_strap_i | input | 1 | External-execution strap |
| movx_i | input | 1 | This cycle accesses external data memory |
| movc_i | input | 1 | This cycle reads a constant from code memory |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address for read and write |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| ale_o | output | 1 | Address-latch strobe, active high |
| rd_o | output | 1 | Program-read strobe, active high |
| pull_o | output | 1 | Weak pull-up enable for the latch pin |

## Verification
The checker verifies the following on every clock:
- latch pulses are exactly two clocks long;
- the read strobe never overlaps the latch strobe, and it always waits one idle clock after the latch falls;
- read pulses last at least three clocks;
- the pull-up never coexists with either strobe;
- the config register's upper bits read zero;
- all outputs are quiet under reset.

Several behaviours are visible only to the bench's cycle model and its pulse-count scenarios, because they depend on the sampled cycle context:
- which pulse a data cycle drops;
- whether the disable bit is honoured or overridden by MOVX, MOVC, external fetch or the strap;
- that an input changed mid-cycle waits for the next cycle boundary.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;

  // Context captured once per machine cycle
  typedef struct packed {
    logic ext_code;     // code fetched from external memory
    logic data_cyc;     // external data-memory cycle
    logic latch_quiet;  // latch strobe suppressed, pin on weak pull-up
  } mc_attr_t;

  localparam mc_attr_t ATTR_RESET = '{ext_code: 1'b0, data_cyc: 1'b0, latch_quiet: 1'b0};

endpackage

// File: rtl/mc_phase_ctr.sv
module mc_phase_ctr #(
  parameter int CLKS = 12,
  parameter int PH_W = $clog2(CLKS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] phase_o,
  output logic            last_o
);

  localparam logic [PH_W-1:0] LAST_PH = PH_W'(CLKS - 1);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_d;

  always_comb begin
    if (ph_q == LAST_PH) ph_d = '0;
    else                 ph_d = ph_q + PH_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else         ph_q <= ph_d;
  end

  assign phase_o = ph_q;
  assign last_o  = (ph_q == LAST_PH);

endmodule

// File: rtl/strobe_cfg_reg.sv
module strobe_cfg_reg #(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 'h8E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ale_off_o
);

  logic off_q;
  logic off_d;
  logic off_en;
  logic unused_wdata;

  assign off_en = wr_i && (addr_i == CFG_ADDR);
  assign off_d  = wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     off_q <= 1'b0;
    else if (off_en) off_q <= off_d;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CFG_ADDR) rdata_o[0] = off_q;
  end

  assign ale_off_o    = off_q;
  assign unused_wdata = ^wdata_i[DATA_W-1:1];

endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
  import bus_strobe_pkg::*;
#(
  parameter int CLKS   = 12,
  parameter int ALE_HI = 2,
  parameter int RD_GAP = 1,
  parameter int PH_W   = $clog2(CLKS)
) (
  input  logic            run_i,
  input  logic [PH_W-1:0] phase_i,
  input  mc_attr_t        attr_i,
  output logic            ale_o,
  output logic            rd_o,
  output logic            pull_o
);

  localparam int              HALF    = CLKS / 2;
  localparam logic [PH_W-1:0] HALF_P  = PH_W'(HALF);
  localparam logic [PH_W-1:0] ALE_END = PH_W'(ALE_HI);
  localparam logic [PH_W-1:0] RD_BEG  = PH_W'(ALE_HI + RD_GAP);

  logic            second;
  logic [PH_W-1:0] sub_ph;

  always_comb begin
    second = (phase_i >= HALF_P);
    sub_ph = second ? (phase_i - HALF_P) : phase_i;
    ale_o  = run_i && !attr_i.latch_quiet && (sub_ph < ALE_END)
             && !(attr_i.data_cyc && second);
    rd_o   = run_i && attr_i.ext_code && !attr_i.data_cyc && (sub_ph >= RD_BEG);
    pull_o = run_i && attr_i.latch_quiet;
  end

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bus_strobe_pkg::*;
#(
  parameter int                CLKS_PER_MC = 12,
  parameter int                ALE_HI      = 2,
  parameter int                RD_GAP      = 1,
  parameter int                SYNC_STAGES = 2,
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR    = 'h8E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_fetch_i,
  input  logic              ext_strap_i,
  input  logic              movx_i,
  input  logic              movc_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              ale_o,
  output logic              rd_o,
  output logic              pull_o
);

  localparam int PH_W = $clog2(CLKS_PER_MC);

  // Reset: asserted at once, released after SYNC_STAGES edges
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[SYNC_STAGES-1];

  // Machine-cycle phase
  logic [PH_W-1:0] phase;
  logic            mc_last;

  mc_phase_ctr #(.CLKS(CLKS_PER_MC), .PH_W(PH_W)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .phase_o (phase),
    .last_o  (mc_last)
  );

  // Latch-disable register
  logic ale_off;

  strobe_cfg_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(CFG_ADDR)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .ale_off_o (ale_off)
  );

  // Per-cycle context, captured at the cycle boundary
  mc_attr_t attr_q;
  mc_attr_t attr_d;
  logic     attr_en;

  assign attr_en = mc_last;

  always_comb begin
    attr_d.ext_code    = ext_fetch_i | ext_strap_i;
    attr_d.data_cyc    = movx_i;
    attr_d.latch_quiet = ale_off & ~ext_strap_i & ~ext_fetch_i & ~movx_i & ~movc_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)       attr_q <= ATTR_RESET;
    else if (attr_en) attr_q <= attr_d;
  end

  // Strobe decode
  strobe_decode #(
    .CLKS(CLKS_PER_MC), .ALE_HI(ALE_HI), .RD_GAP(RD_GAP), .PH_W(PH_W)
  ) u_dec (
    .run_i   (rst_n),
    .phase_i (phase),
    .attr_i  (attr_q),
    .ale_o   (ale_o),
    .rd_o    (rd_o),
    .pull_o  (pull_o)
  );

endmodule

// File: rtl/bus_strobe_chk.sv
module bus_strobe_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ale_o,
  input logic              rd_o,
  input logic              pull_o,
  input logic [DATA_W-1:0] reg_rdata_o
);

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!ale_o && !rd_o && !pull_o && reg_rdata_o == '0)); // R1

  AST_ALE_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ale_o) |=> ale_o); // R2

  AST_ALE_MAX_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_o && $past(ale_o)) |=> !ale_o); // R2

  AST_RD_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ale_o && rd_o)); // R3

  AST_RD_GAP_AFTER_ALE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> !rd_o); // R3

  AST_RD_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_o) |=> (rd_o ##1 rd_o)); // R3

  AST_CFG_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[DATA_W-1:1] == '0); // R5

  AST_PULL_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_o |-> (!ale_o && !rd_o)); // R6

endmodule

bind bus_strobe_gen bus_strobe_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ale_o       (ale_o),
  .rd_o        (rd_o),
  .pull_o      (pull_o),
  .reg_rdata_o (reg_rdata_o)
);

// File: tb/bus_strobe_gen_tb_top.sv
module bus_strobe_gen_tb_top;

  localparam int         MC  = 12;
  localparam logic [7:0] CFG = 8'h8E;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ext_fetch = 1'b0, ext_strap = 1'b0, movx = 1'b0, movc = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ale, rd, pull;

  always #2 clk = ~clk;

  bus_strobe_gen dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ext_fetch_i(ext_fetch), .ext_strap_i(ext_strap),
    .movx_i(movx), .movc_i(movc), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .ale_o(ale), .rd_o(rd), .pull_o(pull)
  );

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  function automatic void chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endfunction

  // Behavioural reference: reset release, cycle position, cycle context
  int m_ph = 0;
  bit m_s1 = 0, m_rel = 0, m_off = 0, m_ext = 0, m_data = 0, m_quiet = 0;

  always @(posedge clk) begin : ref_model
    bit was_rel;
    was_rel = m_rel;
    if (!rst_ni) begin m_s1 = 0; m_rel = 0; end
    else begin m_rel = m_s1; m_s1 = 1; end
    if (!was_rel) begin
      m_ph = 0; m_ext = 0; m_data = 0; m_quiet = 0; m_off = 0;
    end else begin
      if (m_ph == MC - 1) begin
        m_ext   = ext_fetch || ext_strap;
        m_data  = movx;
        m_quiet = m_off && !(ext_strap || ext_fetch || movx || movc);
      end
      if (reg_wr && reg_addr == CFG) m_off = reg_wdata[0];
      m_ph = (m_ph + 1) % MC;
    end
  end

  always @(negedge clk) begin : per_clock_cmp
    bit e_ale, e_rd, e_pull;
    int e_rdata;
    if (cmp_on && !done) begin
      e_ale   = m_rel && !m_quiet &&
                ((m_ph inside {0, 1}) || (!m_data && (m_ph inside {6, 7})));
      e_rd    = m_rel && m_ext && !m_data && (m_ph inside {[3:5], [9:11]});
      e_pull  = m_rel && m_quiet;
      e_rdata = (reg_addr == CFG) ? int'(m_off) : 0;
      chk("R2 latch strobe per clock", int'(ale), int'(e_ale));
      chk("R3 read strobe per clock", int'(rd), int'(e_rd));
      chk("R6 pull-up per clock", int'(pull), int'(e_pull));
      chk("R5 register read per clock", int'(reg_rdata), e_rdata);
    end
  end

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = CFG;
  endtask

  // Count rising edges over three machine cycles once the context is stable
  task automatic measure(input int exp_a, input int exp_r, input string tag);
    int na = 0, nr = 0;
    logic pa, pr;
    repeat (24) @(negedge clk);
    pa = ale; pr = rd;
    repeat (36) begin
      @(negedge clk);
      if (ale && !pa) na++;
      if (rd && !pr) nr++;
      pa = ale; pr = rd;
    end
    chk({tag, " latch pulses"}, na, exp_a);
    chk({tag, " read pulses"}, nr, exp_r);
  endtask

  task automatic report();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    cmp_on = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 latch low in reset", int'(ale), 0);
    chk("R1 pull low in reset", int'(pull), 0);
    reg_addr = CFG;
    @(negedge clk);
    chk("R1 register 0 in reset", int'(reg_rdata), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 strobes quiet one edge after release", int'(ale), 0);
    @(negedge clk);
    chk("R9 first cycle starts with latch pulse", int'(ale), 1);

    measure(6, 0, "R2 internal fetch");

    // R9: context change mid-cycle waits for the boundary
    do @(negedge clk); while (m_ph != 2);
    ext_fetch = 1'b1;
    @(negedge clk);
    chk("R9 no read pulse before boundary", int'(rd), 0);
    repeat (12) @(negedge clk);
    chk("R9 read pulse after boundary", int'(rd), 1);

    measure(6, 6, "R3 external fetch");
    movx = 1'b1;
    measure(3, 0, "R4 data cycle external code");
    ext_fetch = 1'b0;
    measure(3, 0, "R4 data cycle internal code");
    movx = 1'b0;

    reg_write(CFG, 8'hFF);
    @(negedge clk);
    chk("R5 only bit 0 stored", int'(reg_rdata), 1);
    reg_write(8'h8D, 8'h00);
    @(negedge clk);
    chk("R5 other address ignored", int'(reg_rdata), 1);
    reg_addr = 8'h8D;
    @(negedge clk);
    chk("R5 other address reads 0", int'(reg_rdata), 0);
    reg_addr = CFG;

    measure(0, 0, "R6 disabled internal");
    chk("R6 pull-up active", int'(pull), 1);

    movc = 1'b1;
    measure(6, 0, "R7 disabled with movc");
    chk("R7 pull-up off with movc", int'(pull), 0);
    movc = 1'b0; movx = 1'b1;
    measure(3, 0, "R7 disabled with movx");
    movx = 1'b0; ext_fetch = 1'b1;
    measure(6, 6, "R7 disabled with external fetch");
    ext_fetch = 1'b0; ext_strap = 1'b1;
    measure(6, 6, "R8 strap overrides disable");
    chk("R8 pull-up off under strap", int'(pull), 0);
    ext_strap = 1'b0;

    reg_write(CFG, 8'h00);
    @(negedge clk);
    chk("R5 bit cleared", int'(reg_rdata), 0);
    measure(6, 0, "R6 re-enabled latch");

    repeat (3) @(negedge clk);
    report();
  end

endmodule